// File: doc/BRIEF.md
# Bidirectional 24-bit Word Serializer/Deserializer

This block is one end of a narrow serial link that carries 24-bit parallel words. A direction input and a two-bit select decide its role. As a transmitter it latches a parallel word when it sees a rising edge on a strobe input. It then sends that word as a 26-slot frame on one serial data line. A bit-valid line is forwarded next to the data and changes on the same clock edge. As a receiver it looks for the frame's start marker and gathers the 24 data bits. It checks the stop marker, and only then updates its parallel output and drives a word clock. A select value of zero puts the block in a quiet reset mode whatever the direction.

The block runs entirely on the bit-rate clock, which is assumed to come from an outside frequency multiplier. Each serial slot is one clock cycle. When the transmitter has no new word at a frame boundary, it sends an idle frame of all zeros. The receiver never mistakes such a frame for data.

Top module: `wserdes_top`

## Requirements
- R1: With sel = 2'b00 the block is in reset mode whatever dir is. par_oe and word_clk are 0, and one cycle later ser_ck_out and ser_d_out are 0. dir_n always equals the inverse of dir.
- R2: par_oe is 1 exactly when dir = 0 and sel is not 2'b00 (receive mode). It is 0 in transmit mode (dir = 1, sel not 2'b00).
- R3: In transmit mode, par_in is captured at the first clock edge at which strobe is seen high after being seen low. A strobe that is already high when transmit mode is entered is not an edge.
- R4: In transmit mode, frames are 26 cycles long. Their boundaries fall on the first clock edge in transmit mode and every 26 edges after it. After a boundary edge, ser_d_out shows slot 0, the start marker 1. Slots 1..24 carry par_in bits 0..23, least significant first. Slot 25 is the stop marker 0. ser_ck_out is 1 from the first edge in transmit mode onward.
- R5: A word captured during a frame is sent in the next frame. A frame boundary with no capture since the previous boundary sends 26 zeros.
- R6: In receive mode, slots are taken only on edges where ser_ck_in = 1. A 1 while hunting is a start marker. The next 24 slots are data, least significant first. If the slot after them is 0, par_out takes the word at that same edge.
- R7: word_clk is 1 in receive mode except in a window. That window starts 8 cycles after par_out updates and lasts exactly 13 cycles.
- R8: If the stop slot is 1, par_out keeps its old value and frame_err is 1 for exactly one cycle after that edge. word_clk gives no pulse, and the receiver returns to hunting.
- R9: Slots of 0 while hunting (idle frames) leave par_out unchanged and word_clk at 1.
- R10: Edges with ser_ck_in = 0 are ignored, whatever ser_d_in shows.
- R11: A strobe edge seen in reset mode is dropped. The first frame after entering transmit mode is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dir | input | 1 | 1 = transmit, 0 = receive |
| sel | input | 2 | Mode select; 2'b00 forces reset mode |
| dir_n | output | 1 | Inverse of dir |
| strobe | input | 1 | Word strobe, rising edge captures par_in |
| par_in | input | 24 | Parallel word to transmit |
| par_out | output | 24 | Recovered parallel word |
| par_oe | output | 1 | Output enable for par_out and word_clk |
| ser_d_out | output | 1 | Serial data to the link |
| ser_ck_out | output | 1 | Forwarded bit-valid line, edge-aligned with ser_d_out |
| ser_d_in | input | 1 | Serial data from the link |
| ser_ck_in | input | 1 | Bit-valid line from the link |
| word_clk | output | 1 | Recovered word clock, low for 13 cycles per word |
| frame_err | output | 1 | One-cycle pulse on a bad stop marker |

## Verification
Transmit slots are due one edge after their frame boundary. The bench therefore drives inputs at falling edges, steps one rising edge, and compares the serial output with the frame bit for that cycle index. The capture edge for a strobe comes one rising edge after the strobe is driven high. In receive mode, par_out and frame_err are due at the edge that takes the stop slot and are sampled at the next falling edge. word_clk is then checked at every one of the following 25 cycles: it must be low in cycles 8 through 20 and high at all others.

// File: rtl/wserdes_pkg.sv
// Shared types for the word serializer/deserializer.
package wserdes_pkg;
    typedef enum logic [1:0] {
        MD_RESET = 2'd0,
        MD_TX    = 2'd1,
        MD_RX    = 2'd2
    } mode_e;
endpackage

// File: rtl/wsd_mode_dec.sv
// Mode decoder: turns direction and select into one operating mode.
// Assumes select value zero always wins over direction.
module wsd_mode_dec
    import wserdes_pkg::*;
(
    input  logic       dir,
    input  logic [1:0] sel,
    output mode_e      mode
);
    // Decode the mode table.
    always_comb begin
        if (sel == 2'b00)
            mode = MD_RESET;
        else if (dir)
            mode = MD_TX;
        else
            mode = MD_RX;
    end
endmodule

// File: rtl/wsd_tx.sv
// Transmit path: captures a word on a strobe rising edge and sends it as a
// start-marker, data (LSB first), stop-marker frame. Sends zeros when no word
// is pending. Assumes strobe is synchronous to clk. State clears when en is low.
module wsd_tx #(
    parameter int DW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          strobe,
    input  logic [DW-1:0] par_in,
    output logic          ser_d,
    output logic          ser_ck
);
    localparam int FB = DW + 2;
    localparam int CW = $clog2(FB);

    logic          strb_q;
    logic [DW-1:0] pend;
    logic          pv;
    logic [CW-1:0] fcnt;
    logic [FB-1:0] sh;
    logic [FB-1:0] nxt_frame;
    logic          rise;

    // Strobe edge and the frame to load at the next boundary.
    always_comb begin
        rise      = strobe & ~strb_q;
        nxt_frame = pv ? {1'b0, pend, 1'b1} : '0;
    end

    // Capture, frame counting and shifting.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            strb_q <= 1'b1;
            pend   <= '0;
            pv     <= 1'b0;
            fcnt   <= '0;
            sh     <= '0;
            ser_d  <= 1'b0;
            ser_ck <= 1'b0;
        end else begin
            strb_q <= strobe;
            ser_ck <= 1'b1;
            if (fcnt == '0) begin
                ser_d <= nxt_frame[0];
                sh    <= nxt_frame >> 1;
                pv    <= 1'b0;
            end else begin
                ser_d <= sh[0];
                sh    <= sh >> 1;
            end
            if (rise) begin
                pend <= par_in;
                pv   <= 1'b1;
            end
            fcnt <= (fcnt == CW'(FB - 1)) ? '0 : fcnt + 1'b1;
        end
    end
endmodule

// File: rtl/wsd_rx.sv
// Receive path: hunts for a start marker, gathers DW bits LSB first, checks
// the stop marker, then updates the word and runs the word-clock window.
// Assumes one slot per clk edge with ser_ck high. State clears when en is low.
module wsd_rx #(
    parameter int DW   = 24,
    parameter int LEAD = 8,
    parameter int LOWT = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          ser_d,
    input  logic          ser_ck,
    output logic [DW-1:0] par_out,
    output logic          word_clk,
    output logic          frame_err
);
    localparam int FB = DW + 2;
    localparam int CW = $clog2(FB);
    localparam int WC = LEAD + LOWT;
    localparam int WW = $clog2(WC + 1);

    logic          hunt;
    logic [CW-1:0] rcnt;
    logic [DW-1:0] sh;
    logic [WW-1:0] wcnt;

    // Framing, assembly, stop check and word-clock countdown.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            hunt      <= 1'b1;
            rcnt      <= '0;
            sh        <= '0;
            par_out   <= '0;
            frame_err <= 1'b0;
            wcnt      <= '0;
        end else begin
            frame_err <= 1'b0;
            if (wcnt != '0)
                wcnt <= wcnt - 1'b1;
            if (ser_ck) begin
                if (hunt) begin
                    if (ser_d) begin
                        hunt <= 1'b0;
                        rcnt <= CW'(1);
                    end
                end else if (rcnt == CW'(FB - 1)) begin
                    hunt <= 1'b1;
                    if (!ser_d) begin
                        par_out <= sh;
                        wcnt    <= WW'(WC);
                    end else begin
                        frame_err <= 1'b1;
                    end
                end else begin
                    sh   <= {ser_d, sh[DW-1:1]};
                    rcnt <= rcnt + 1'b1;
                end
            end
        end
    end

    // Word clock is low during the last LOWT counts of the countdown.
    always_comb
        word_clk = en && !((wcnt != '0) && (wcnt <= WW'(LOWT)));
endmodule

// File: rtl/wserdes_top.sv
// Top of the bidirectional word serdes: mode decode, transmit and receive
// paths, and output enables. Assumes clk runs at the serial bit rate.
module wserdes_top
    import wserdes_pkg::*;
#(
    parameter int DW   = 24,
    parameter int LEAD = 8,
    parameter int LOWT = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dir,
    input  logic [1:0]    sel,
    output logic          dir_n,
    input  logic          strobe,
    input  logic [DW-1:0] par_in,
    output logic [DW-1:0] par_out,
    output logic          par_oe,
    output logic          ser_d_out,
    output logic          ser_ck_out,
    input  logic          ser_d_in,
    input  logic          ser_ck_in,
    output logic          word_clk,
    output logic          frame_err
);
    mode_e mode;
    logic  tx_en;
    logic  rx_en;

    wsd_mode_dec u_dec (.dir(dir), .sel(sel), .mode(mode));

    // Path enables and pin-level controls.
    always_comb begin
        tx_en  = (mode == MD_TX);
        rx_en  = (mode == MD_RX);
        par_oe = rx_en;
        dir_n  = ~dir;
    end

    wsd_tx #(.DW(DW)) u_tx (
        .clk(clk), .rst_n(rst_n), .en(tx_en), .strobe(strobe),
        .par_in(par_in), .ser_d(ser_d_out), .ser_ck(ser_ck_out)
    );

    wsd_rx #(.DW(DW), .LEAD(LEAD), .LOWT(LOWT)) u_rx (
        .clk(clk), .rst_n(rst_n), .en(rx_en), .ser_d(ser_d_in),
        .ser_ck(ser_ck_in), .par_out(par_out), .word_clk(word_clk),
        .frame_err(frame_err)
    );
endmodule

// File: rtl/wserdes_chk.sv
// Checker for wserdes_top: port-level timing properties, bound to the top.
module wserdes_chk #(
    parameter int DW   = 24,
    parameter int LOWT = 13
) (
    input logic          clk,
    input logic          rst_n,
    input logic          dir,
    input logic [1:0]    sel,
    input logic [DW-1:0] par_out,
    input logic          par_oe,
    input logic          ser_ck_out,
    input logic          word_clk,
    input logic          frame_err
);
    logic       rx_m;
    logic       tx_m;
    logic [7:0] lowcnt;

    always_comb begin
        rx_m = !dir && (sel != 2'b00);
        tx_m = dir && (sel != 2'b00);
    end

    // Count consecutive low word-clock cycles in receive mode.
    always_ff @(posedge clk) begin
        if (!rst_n || !rx_m || word_clk)
            lowcnt <= '0;
        else
            lowcnt <= lowcnt + 1'b1;
    end

    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 2'b00) |-> (!par_oe && !word_clk));
    p_reset_serial_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 2'b00) |=> !ser_ck_out);
    p_tx_no_oe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_m |-> !par_oe);
    p_tx_ck_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_m |=> (ser_ck_out || !tx_m || $past(!rst_n)));
    p_update_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_m && $past(rx_m) && (par_out != $past(par_out))) |-> word_clk);
    p_low13_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_m && $past(rx_m) && $rose(word_clk)) |-> (lowcnt == 8'(LOWT)));
    p_err_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> !frame_err);
    p_err_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_err && rx_m && $past(rx_m)) |-> $stable(par_out));
endmodule

bind wserdes_top wserdes_chk #(.DW(DW), .LOWT(LOWT)) u_chk (
    .clk(clk), .rst_n(rst_n), .dir(dir), .sel(sel), .par_out(par_out),
    .par_oe(par_oe), .ser_ck_out(ser_ck_out), .word_clk(word_clk),
    .frame_err(frame_err)
);

// File: tb/sim_wserdes_top.sv
module sim_wserdes_top;
    localparam int DW = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          dir = 1'b0;
    logic [1:0]    sel = 2'b00;
    logic          dir_n;
    logic          strobe = 1'b0;
    logic [DW-1:0] par_in = '0;
    logic [DW-1:0] par_out;
    logic          par_oe;
    logic          ser_d_out;
    logic          ser_ck_out;
    logic          ser_d_in = 1'b0;
    logic          ser_ck_in = 1'b0;
    logic          word_clk;
    logic          frame_err;

    int n_chk = 0;
    int n_fail = 0;
    logic done = 1'b0;

    always #10 clk = ~clk;

    wserdes_top u0 (
        .clk(clk), .rst_n(rst_n), .dir(dir), .sel(sel), .dir_n(dir_n),
        .strobe(strobe), .par_in(par_in), .par_out(par_out), .par_oe(par_oe),
        .ser_d_out(ser_d_out), .ser_ck_out(ser_ck_out), .ser_d_in(ser_d_in),
        .ser_ck_in(ser_ck_in), .word_clk(word_clk), .frame_err(frame_err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Drive one receive slot, step one edge, return at the falling edge.
    task automatic send_bit(input logic b, input logic ck);
        ser_d_in = b;
        ser_ck_in = ck;
        step();
    endtask

    // Send a frame (optionally with ignored gap slots) and check the result.
    task automatic rx_frame(input logic [DW-1:0] w, input logic stop_bit, input logic gaps);
        logic [DW-1:0] prev;
        prev = par_out;
        send_bit(1'b1, 1'b1);
        for (int i = 0; i < DW; i++) begin
            if (gaps) send_bit(1'b1, 1'b0);
            send_bit(w[i], 1'b1);
        end
        send_bit(stop_bit, 1'b1);
        if (!stop_bit) begin
            check(gaps ? "R10 gapped word" : "R6 word", par_out, w);
            check("R6 no error", frame_err, 0);
        end else begin
            check("R8 word held", par_out, prev);
            check("R8 error pulse", frame_err, 1);
        end
        for (int k = 1; k <= 25; k++) begin
            send_bit(1'b0, 1'b1);
            if (!stop_bit)
                check("R7 word clock", word_clk, (k >= 8 && k <= 20) ? 0 : 1);
            else
                check("R8 no word clock", word_clk, 1);
            if (k == 1) check("R8 error one cycle", frame_err, 0);
            if (k == 25) check("R9 idle holds word", par_out, stop_bit ? prev : w);
        end
    endtask

    // Run one transmit frame from slot 0, optionally strobing a word in.
    task automatic tx_frame(input logic [DW+1:0] exp, input logic do_strb,
                            input logic [DW-1:0] w, input string req);
        for (int k = 0; k < DW + 2; k++) begin
            check(req, ser_d_out, exp[k]);
            check("R4 bit valid", ser_ck_out, 1);
            if (do_strb && k == 0) begin
                par_in = w;
                strobe = 1'b1;
            end
            if (k == 1) strobe = 1'b0;
            step();
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] wa;
        logic [DW-1:0] wb;
        wa = 24'h5A3C96;
        wb = 24'h800001;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1 reset state with both directions.
        check("R1 oe in reset", par_oe, 0);
        check("R1 word clock in reset", word_clk, 0);
        check("R1 serial clock in reset", ser_ck_out, 0);
        check("R1 serial data in reset", ser_d_out, 0);
        check("R1 dir_n", dir_n, 1);
        dir = 1'b1;
        step();
        check("R1 oe in reset dir=1", par_oe, 0);
        check("R1 dir_n dir=1", dir_n, 0);
        // R11: strobe edge in reset mode is dropped.
        par_in = '1;
        strobe = 1'b1;
        step();
        strobe = 1'b0;
        step();
        // Enter transmit mode; first edge is a frame boundary.
        sel = 2'b01;
        step();
        check("R2 oe in transmit", par_oe, 0);
        tx_frame('0, 1'b1, wa, "R11 idle after reset");
        tx_frame({1'b0, wa, 1'b1}, 1'b1, wb, "R4 frame A R3");
        tx_frame({1'b0, wb, 1'b1}, 1'b0, '0, "R4 frame B R3");
        tx_frame('0, 1'b0, '0, "R5 idle frame");
        // Back to reset, then receive mode.
        sel = 2'b00;
        step();
        check("R1 serial clock after reset entry", ser_ck_out, 0);
        dir = 1'b0;
        sel = 2'b10;
        step();
        check("R2 oe in receive", par_oe, 1);
        check("R9 word clock idle", word_clk, 1);
        for (int i = 0; i < DW; i++)
            rx_frame(24'(1) << i, 1'b0, 1'b0);
        rx_frame('1, 1'b0, 1'b0);
        rx_frame(wa, 1'b0, 1'b0);
        rx_frame(24'h123456, 1'b1, 1'b0);
        rx_frame(wb, 1'b0, 1'b1);
        rx_frame(24'hC0FFEE, 1'b0, 1'b0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule